// File: doc/BRIEF.md
# Interrupt Redirection Router

This block connects a set of external interrupt lines to the processors of a chip. Each line owns one 64-bit redirection entry. The entry holds the vector to deliver, a delivery mode, a destination mode, a destination ID, the input polarity, the trigger type and a mask. The block normalises each line to active-high and detects either a rising edge or an active level. It then issues one delivery message at a time on an output with a valid/ready handshake. The message carries the entry's vector, mode, destination mode and destination ID.

Software reaches the entries only through two bus addresses. A select register at offset 0x00 holds a register index. A data window at offset 0x10 reads or writes the register that the select register names. Index 0 is an identification word and index 1 is a version word. Entry k takes index 0x10+2k for its low word and index 0x10+2k+1 for its high word.

A level-triggered entry sets a remote in-service flag when its message is accepted. An end-of-interrupt carrying the same vector clears that flag, and the entry may then fire again. A delivery state machine has two states. `ST_IDLE` moves to `ST_OFFER` (the take transition) when any entry is requesting. It latches the lowest-numbered requester and that entry's payload. `ST_OFFER` returns to `ST_IDLE` (the done transition) in the cycle the handshake completes.

Top module: `rtr_router`

## Requirements
- R1: A write to bus offset 0x00 loads the select index from bits 7:0, and a read of offset 0x00 returns that index in bits 7:0 with zeros above. A read or write at offset 0x10 acts on the register named by the select index. Reads at any other offset return zero.
- R2: Index 0 reads as the identification word `{4'h0, DEV_ID, 24'h0}`. Index 1 reads as the version word, which carries NUM_IN-1 in bits 23:16 and VERSION in bits 7:0. Writes to either index have no effect.
- R3: The low word of an entry holds these fields: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11 (1 = logical), polarity in bit 13 (1 = active low), trigger in bit 15 (1 = level) and mask in bit 16. The high word holds the destination ID in bits 31:24. After reset every entry reads 0x0001_0000 for the low word and 0 for the high word.
- R4: Writes to bit 12 (delivery pending) and bit 14 (remote in-service) are ignored. Reserved bits read as zero. Window accesses to an index that is neither 0, 1 nor a table entry are discarded on write and read as zero.
- R5: An unmasked edge entry issues exactly one message per rising edge of its corrected input. The message carries the entry's vector, mode, destination mode and destination ID. It is offered on the second clock edge after the edge is sampled.
- R6: With polarity set, the input is inverted before detection, so a falling pin edge counts as the active edge.
- R7: A masked entry issues no message, and edges that arrive while it is masked are dropped. Setting the mask bit by read-modify-write leaves every other field of the entry unchanged.
- R8: An entry whose vector is below 32 never issues a message.
- R9: A level entry issues a message while its corrected input is active and its remote in-service flag is clear. The flag sets when that message is accepted. An end-of-interrupt with a matching vector clears the flag, and a still-active input then issues a new message. An end-of-interrupt with a different vector does not clear it.
- R10: Bit 12 of the low word reads 1 from detection until the entry's message handshake completes, and 0 afterwards.
- R11: At most one message is outstanding. Its payload holds stable while msg_ready is low. When several entries request at once, the lowest entry index is sent first.
- R12: A new edge on an entry in the cycle its previous message is accepted is kept and delivered. A matching end-of-interrupt in the cycle a level entry's message is accepted leaves remote in-service set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_IN | Interrupt input lines, synchronous to clk |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The bench targets two pairs of functions that can land on the same clock edge. A fresh edge can arrive in the cycle that an entry's earlier message is accepted. A matching end-of-interrupt can arrive in the cycle that a level entry's message is accepted. Both cases are provoked by holding msg_ready low until a message waits, then raising msg_ready in the same drive as the new edge or the end-of-interrupt. They are judged by the number of messages the output port delivers and by the remote in-service bit read back through the window. A behavioural model of the requirements runs in lockstep and is compared with the message port on every clock.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    // Per-entry configuration held by the register file
    typedef struct packed {
        logic [7:0] dest;     // destination ID
        logic       mask;     // 1 = input disabled
        logic       trig;     // 1 = level, 0 = edge
        logic       pol;      // 1 = active low
        logic       logical;  // destination mode
        logic [2:0] mode;     // delivery mode
        logic [7:0] vec;      // vector
    } rte_cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } dlv_state_t;

    localparam logic [7:0] MIN_VEC = 8'd32;
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_TBL = 8'h10;

endpackage

// File: rtl/rtr_regfile.sv
module rtr_regfile
    import rtr_pkg::*;
#(
    parameter int         N       = 8,
    parameter int         KW      = 3,
    parameter logic [3:0] DEV_ID  = 4'd2,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [N-1:0]         status_i,
    input  logic [N-1:0]         rirr_i,
    output rte_cfg_t [N-1:0]     cfg_o
);

    localparam int TBL_END = int'(IDX_TBL) + 2 * N;

    logic [7:0]        sel_q;
    rte_cfg_t [N-1:0]  cfg_q;
    logic [7:0]        off;
    logic [KW-1:0]     k;
    logic              hi_word;
    logic              in_tbl;
    logic              win_wr;
    logic              wdata_unused;

    assign off     = sel_q - IDX_TBL;
    assign k       = KW'(off >> 1);
    assign hi_word = off[0];
    assign in_tbl  = (sel_q >= IDX_TBL) && (int'(sel_q) < TBL_END);
    assign win_wr  = bus_wr && (bus_addr == OFF_WIN) && in_tbl;
    assign wdata_unused = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            for (int i = 0; i < N; i++) begin
                cfg_q[i] <= '{mask: 1'b1, default: '0};
            end
        end else if (bus_wr && (bus_addr == OFF_SEL)) begin
            sel_q <= bus_wdata[7:0];
        end else if (win_wr) begin
            if (hi_word) begin
                cfg_q[k].dest <= bus_wdata[31:24];
            end else begin
                cfg_q[k].vec     <= bus_wdata[7:0];
                cfg_q[k].mode    <= bus_wdata[10:8];
                cfg_q[k].logical <= bus_wdata[11];
                cfg_q[k].pol     <= bus_wdata[13];
                cfg_q[k].trig    <= bus_wdata[15];
                cfg_q[k].mask    <= bus_wdata[16];
            end
        end
    end

    assign cfg_o = cfg_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_SEL) begin
            bus_rdata = {24'h0, sel_q};
        end else if (bus_addr == OFF_WIN) begin
            if (sel_q == IDX_ID) begin
                bus_rdata = {4'h0, DEV_ID, 24'h0};
            end else if (sel_q == IDX_VER) begin
                bus_rdata = {8'h0, 8'(N - 1), 8'h0, VERSION};
            end else if (in_tbl) begin
                if (hi_word) begin
                    bus_rdata = {cfg_q[k].dest, 24'h0};
                end else begin
                    bus_rdata = {15'h0, cfg_q[k].mask, cfg_q[k].trig, rirr_i[k],
                                 cfg_q[k].pol, status_i[k], cfg_q[k].logical,
                                 cfg_q[k].mode, cfg_q[k].vec};
                end
            end
        end
    end

    // R4
    tbl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_WIN) && !in_tbl) |=> $stable(cfg_q));

    // R1
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_SEL)) |=> (sel_q == $past(bus_wdata[7:0])));

endmodule

// File: rtl/rtr_source.sv
module rtr_source
    import rtr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq,
    input  rte_cfg_t   cfg,
    input  logic       hs_this,
    input  logic       busy_this,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       req_o,
    output logic       status_o,
    output logic       rirr_o
);

    logic corr;
    logic eligible;
    logic edge_hit;
    logic eoi_hit;
    logic prev_q;
    logic pend_q;
    logic rirr_q;

    assign corr     = irq ^ cfg.pol;
    assign eligible = !cfg.mask && (cfg.vec >= MIN_VEC);
    assign edge_hit = !cfg.trig && eligible && corr && !prev_q;
    assign eoi_hit  = eoi_valid && cfg.trig && (eoi_vector == cfg.vec);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            prev_q <= corr;
            if (edge_hit) begin
                pend_q <= 1'b1;
            end else if (hs_this) begin
                pend_q <= 1'b0;
            end
            if (hs_this && cfg.trig) begin
                rirr_q <= 1'b1;
            end else if (eoi_hit) begin
                rirr_q <= 1'b0;
            end
        end
    end

    assign req_o    = eligible && (cfg.trig ? (corr && !rirr_q) : pend_q);
    assign status_o = req_o || busy_this;
    assign rirr_o   = rirr_q;

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !hs_this) |=> pend_q);

    // R9
    rirr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_q && !eoi_hit) |=> rirr_q);

    // R12
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_this && cfg.trig) |=> rirr_q);

endmodule

// File: rtl/rtr_pick.sv
module rtr_pick #(
    parameter int N  = 8,
    parameter int KW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [KW-1:0] idx_o
);

    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = KW'(i);
            end
        end
    end

endmodule

// File: rtl/rtr_router.sv
module rtr_router
    import rtr_pkg::*;
#(
    parameter int         NUM_IN  = 8,
    parameter logic [3:0] DEV_ID  = 4'd2,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_logical,
    output logic [7:0]        msg_dest,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector
);

    localparam int KW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    rte_cfg_t [NUM_IN-1:0] cfg_w;
    logic [NUM_IN-1:0]     req_vec;
    logic [NUM_IN-1:0]     status_vec;
    logic [NUM_IN-1:0]     rirr_vec;
    logic [NUM_IN-1:0]     hs_vec;
    logic [NUM_IN-1:0]     busy_vec;
    logic                  pick_found;
    logic [KW-1:0]         pick_idx;

    dlv_state_t st_q, st_d;
    logic [KW-1:0] cur_q;
    rte_cfg_t      pay_q;
    logic          offering;
    logic          hs;
    logic          take;

    rtr_regfile #(
        .N(NUM_IN), .KW(KW), .DEV_ID(DEV_ID), .VERSION(VERSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_i  (status_vec),
        .rirr_i    (rirr_vec),
        .cfg_o     (cfg_w)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_src
        assign hs_vec[g]   = hs && (cur_q == KW'(g));
        assign busy_vec[g] = offering && (cur_q == KW'(g));

        rtr_source u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq        (irq_in[g]),
            .cfg        (cfg_w[g]),
            .hs_this    (hs_vec[g]),
            .busy_this  (busy_vec[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .req_o      (req_vec[g]),
            .status_o   (status_vec[g]),
            .rirr_o     (rirr_vec[g])
        );
    end

    rtr_pick #(.N(NUM_IN), .KW(KW)) u_pick (
        .req_i   (req_vec),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d     = st_q;
        offering = 1'b0;
        take     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (pick_found) begin
                    take = 1'b1;
                    st_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                offering = 1'b1;
                if (msg_ready) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign hs = offering && msg_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            pay_q <= '0;
        end else if (take) begin
            cur_q <= pick_idx;
            pay_q <= cfg_w[pick_idx];
        end
    end

    assign msg_valid   = offering;
    assign msg_vector  = pay_q.vec;
    assign msg_mode    = pay_q.mode;
    assign msg_logical = pay_q.logical;
    assign msg_dest    = pay_q.dest;

    // R11
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid &&
            $stable({msg_vector, msg_mode, msg_logical, msg_dest})));

    // R11
    one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    // R8
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_vector >= MIN_VEC));

    // R11
    pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> (req_vec[pick_idx] &&
            ((req_vec & ((NUM_IN'(1) << pick_idx) - NUM_IN'(1))) == '0)));

endmodule

// File: tb/tb_rtr_router.sv
module tb_rtr_router;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_logical;
    logic [7:0]  msg_dest;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int dcnt [256];

    always #10 clk = ~clk;

    rtr_router dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_vec [N];
    bit [2:0] m_mode [N];
    bit       m_log [N], m_pol [N], m_trig [N], m_mask [N];
    bit [7:0] m_dest [N];
    bit       m_pend [N], m_rirr [N], m_prev [N];
    bit [7:0] m_sel;
    bit       m_busy;
    int       m_cur;
    bit [7:0] o_vec, o_dest;
    bit [2:0] o_mode;
    bit       o_log;

    function automatic bit m_req(int i);
        bit act, ok;
        act = irq_in[i] ^ m_pol[i];
        ok  = !m_mask[i] && (m_vec[i] >= 32);
        return ok && (m_trig[i] ? (act && !m_rirr[i]) : m_pend[i]);
    endfunction

    function automatic bit m_status(int i);
        return m_req(i) || (m_busy && m_cur == i);
    endfunction

    always @(posedge clk) begin
        bit r [N];
        bit eh [N];
        bit hs;
        int pick;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_vec[i] = 0; m_mode[i] = 0; m_log[i] = 0; m_pol[i] = 0;
                m_trig[i] = 0; m_mask[i] = 1; m_dest[i] = 0;
                m_pend[i] = 0; m_rirr[i] = 0; m_prev[i] = 0;
            end
            m_sel = 0; m_busy = 0; m_cur = 0;
            o_vec = 0; o_dest = 0; o_mode = 0; o_log = 0;
        end else begin
            hs = m_busy && msg_ready;
            for (int i = 0; i < N; i++) begin
                r[i]  = m_req(i);
                eh[i] = !m_trig[i] && (irq_in[i] ^ m_pol[i]) && !m_prev[i]
                        && !m_mask[i] && (m_vec[i] >= 32);
            end
            pick = -1;
            if (!m_busy) begin
                for (int i = N - 1; i >= 0; i--) if (r[i]) pick = i;
            end
            for (int i = 0; i < N; i++) begin
                if (eh[i]) m_pend[i] = 1;
                else if (hs && m_cur == i) m_pend[i] = 0;
                if (hs && m_cur == i && m_trig[i]) m_rirr[i] = 1;
                else if (eoi_valid && m_trig[i] && m_vec[i] == eoi_vector) m_rirr[i] = 0;
                m_prev[i] = irq_in[i] ^ m_pol[i];
            end
            if (hs) m_busy = 0;
            else if (pick >= 0) begin
                m_busy = 1; m_cur = pick;
                o_vec = m_vec[pick]; o_mode = m_mode[pick];
                o_log = m_log[pick]; o_dest = m_dest[pick];
            end
            if (bus_wr && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
            else if (bus_wr && bus_addr == 8'h10 && m_sel >= 16 && m_sel < 16 + 2 * N) begin
                int k;
                k = (m_sel - 16) >> 1;
                if (m_sel[0]) m_dest[k] = bus_wdata[31:24];
                else begin
                    m_vec[k] = bus_wdata[7:0]; m_mode[k] = bus_wdata[10:8];
                    m_log[k] = bus_wdata[11]; m_pol[k] = bus_wdata[13];
                    m_trig[k] = bus_wdata[15]; m_mask[k] = bus_wdata[16];
                end
            end
        end
    end

    // Count messages actually accepted at the DUT port
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) dcnt[msg_vector]++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Lockstep comparison of the message port
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 msg_valid vs model", {31'b0, msg_valid}, {31'b0, m_busy});
            if (m_busy && msg_valid)
                chk("R5 payload vs model", {msg_vector, msg_mode, msg_logical, msg_dest},
                    {o_vec, o_mode, o_log, o_dest});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic steps(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(); bus_wr = 1'b0;
    endtask

    task automatic wr_ind(input logic [7:0] idx, input logic [31:0] d);
        wr(8'h00, idx);
        wr(8'h10, d);
    endtask

    task automatic rd_ind(input logic [7:0] idx, output logic [31:0] v);
        wr(8'h00, idx);
        bus_addr = 8'h10;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic eoi(input logic [7:0] v);
        step(); eoi_valid = 1'b1; eoi_vector = v;
        step(); eoi_valid = 1'b0;
    endtask

    function automatic logic [31:0] lo(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic lg, input logic pol,
                                       input logic trig, input logic mask);
        return {15'h0, mask, trig, 1'b0, pol, 1'b0, lg, mode, vec};
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, base;
        steps(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset msg_valid", {31'b0, msg_valid}, 32'h0);
        bus_addr = 8'h00;
        @(negedge clk);
        chk("R1 reset select", bus_rdata, 32'h0);

        // R3 reset entry state
        rd_ind(8'h10, v); chk("R3 reset low word", v, 32'h0001_0000);
        rd_ind(8'h11, v); chk("R3 reset high word", v, 32'h0);

        // R1 / R2
        wr(8'h00, 32'hFFFF_FF01);
        bus_addr = 8'h00; @(negedge clk);
        chk("R1 select readback", bus_rdata, 32'h0000_0001);
        bus_addr = 8'h10; @(negedge clk);
        chk("R2 version word", bus_rdata, {8'h0, 8'(N - 1), 8'h0, 8'h20});
        bus_addr = 8'h08; @(negedge clk);
        chk("R1 other offset reads zero", bus_rdata, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_ind(8'h01, v); chk("R2 version ignores write", v, {8'h0, 8'(N - 1), 8'h0, 8'h20});
        rd_ind(8'h00, v); chk("R2 identification word", v, 32'h0200_0000);

        // R3 entry 2 layout
        wr_ind(8'h14, lo(8'h40, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0));
        wr_ind(8'h15, 32'hA512_3456);
        rd_ind(8'h15, v); chk("R3 high word dest only", v, 32'hA500_0000);
        rd_ind(8'h14, v); chk("R3 low word fields", v, 32'h0000_0B40);

        // R5 edge delivery
        irq_in[2] = 1'b1; steps(6); irq_in[2] = 1'b0; steps(3);
        chk("R5 one message per edge", dcnt[8'h40], 1);

        // R4 read-only and reserved bits, out-of-range index
        wr_ind(8'h14, lo(8'h40, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0) | 32'hFFFE_5000);
        rd_ind(8'h14, v); chk("R4 ro and reserved bits", v, 32'h0000_0B40);
        wr_ind(8'(16 + 2 * N), 32'hFFFF_FFFF);
        rd_ind(8'(16 + 2 * N), v); chk("R4 out-of-range reads zero", v, 32'h0);
        rd_ind(8'(15 + 2 * N), v); chk("R4 last entry untouched", v, 32'h0);
        wr_ind(8'h05, 32'hFFFF_FFFF);
        rd_ind(8'h05, v); chk("R4 gap index reads zero", v, 32'h0);

        // R6 active-low entry 3
        irq_in[3] = 1'b1;
        wr_ind(8'h16, lo(8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
        steps(3);
        chk("R6 idle high gives no message", dcnt[8'h41], 0);
        irq_in[3] = 1'b0; steps(4);
        chk("R6 falling pin edge delivered", dcnt[8'h41], 1);

        // R7 mask by read-modify-write
        rd_ind(8'h14, base);
        wr_ind(8'h14, base | 32'h0001_0000);
        rd_ind(8'h14, v); chk("R7 rmw keeps other fields", v, base | 32'h0001_0000);
        irq_in[2] = 1'b1; steps(2); irq_in[2] = 1'b0; steps(3);
        chk("R7 masked edge not delivered", dcnt[8'h40], 1);
        wr_ind(8'h14, base); steps(4);
        chk("R7 edge dropped while masked", dcnt[8'h40], 1);

        // R8 low vector
        wr_ind(8'h18, lo(8'h1F, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        irq_in[4] = 1'b1; steps(2); irq_in[4] = 1'b0; steps(4);
        chk("R8 vector below 32 not sent", dcnt[8'h1F], 0);

        // R9 level entry 5 with remote in-service
        wr_ind(8'h1A, lo(8'h50, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        irq_in[5] = 1'b1; steps(8);
        chk("R9 level sends once", dcnt[8'h50], 1);
        rd_ind(8'h1A, v); chk("R9 remote in-service set", v, 32'h0000_C050);
        eoi(8'h51); steps(4);
        chk("R9 other vector eoi ignored", dcnt[8'h50], 1);
        eoi(8'h50); steps(4);
        chk("R9 eoi re-issues active level", dcnt[8'h50], 2);
        irq_in[5] = 1'b0; eoi(8'h50); steps(4);
        chk("R9 inactive level after eoi", dcnt[8'h50], 2);
        rd_ind(8'h1A, v); chk("R9 remote in-service cleared", v, 32'h0000_8050);

        // R10 delivery-pending status
        msg_ready = 1'b0;
        irq_in[2] = 1'b1; steps(2); irq_in[2] = 1'b0; steps(2);
        rd_ind(8'h14, v); chk("R10 pending while waiting", v, 32'h0000_1B40);
        chk("R10 message offered", {31'b0, msg_valid}, 32'h1);
        step(); msg_ready = 1'b1; steps(3);
        rd_ind(8'h14, v); chk("R10 pending cleared after handshake", v, 32'h0000_0B40);
        chk("R10 message counted", dcnt[8'h40], 2);

        // R11 lowest index first
        wr_ind(8'h12, lo(8'h61, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0));
        wr_ind(8'h1C, lo(8'h62, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0));
        msg_ready = 1'b0;
        irq_in[1] = 1'b1; irq_in[6] = 1'b1; steps(4);
        @(negedge clk);
        chk("R11 lowest index offered first", {24'h0, msg_vector}, 32'h61);
        step(); msg_ready = 1'b1; steps(5);
        chk("R11 first delivered", dcnt[8'h61], 1);
        chk("R11 second delivered", dcnt[8'h62], 1);
        irq_in[1] = 1'b0; irq_in[6] = 1'b0; steps(2);

        // R12 new edge in the handshake cycle
        msg_ready = 1'b0;
        irq_in[2] = 1'b1; step(); irq_in[2] = 1'b0; steps(3);
        msg_ready = 1'b1; irq_in[2] = 1'b1;
        step(); irq_in[2] = 1'b0; steps(5);
        chk("R12 edge at handshake kept", dcnt[8'h40], 4);

        // R12 matching eoi in the handshake cycle
        msg_ready = 1'b0;
        irq_in[5] = 1'b1; steps(3);
        msg_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h50;
        step(); eoi_valid = 1'b0; steps(5);
        chk("R12 single level message", dcnt[8'h50], 3);
        rd_ind(8'h1A, v); chk("R12 set wins over eoi", v, 32'h0000_C050);
        irq_in[5] = 1'b0; eoi(8'h50); steps(3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule